// File: doc/BRIEF.md
# AUX Channel Request Controller

This block turns a host request for a sideband link access into the four-byte request header the link expects, hands that header (and any write payload) to a lower transaction engine, and reads back the engine's completion. Three request families are handled: native reads and native writes of up to sixteen bytes, and single-byte I2C transfers carried over the link (read, write, and address-only, each with or without a stop).

Every completion is classed by two things: the engine's link status, and the reply command nibble the sink returned. A busy status is retried at once. A deferral, at either the native or the I2C level, holds off for a programmable number of clock cycles and then retries. Any other outcome ends the request. No request is tried more than a fixed number of times. The host gets one done pulse with a result code, the clipped count of received bytes and the received data.

Top module: `aux_req_ctrl`

## Requirements
- R1: Each issued header carries the address low byte in txn_hdr[7:0] and the high byte in txn_hdr[15:8]. Its command byte txn_hdr[23:16] holds the command in its upper nibble: native write 8, native read 9, I2C write 0, I2C read 1, and address-only I2C uses 0. req_kind is coded as 0 native write, 1 native read, 2 I2C write, 3 I2C read, 4 I2C address-only.
- R2: The length byte txn_hdr[31:24] of a native write is ((len+4) mod 16) in the upper nibble and len-1 in the lower nibble. A native read uses 4 and len-1. An I2C write uses 0x50 and an I2C read 0x40. txn_msg_len is len+4 for a native write, 5 for an I2C write and 4 otherwise. txn_wdata forwards the payload.
- R3: A native request whose length is 0 or above MAX_PAYLOAD, or a req_kind above 4, issues no transaction. Done rises on the cycle after acceptance with result 5 (bad request).
- R4: A request is issued at most MAX_TRIES times. When every try ends in busy or deferral, the result is 2 (I/O error) for native requests and 4 (remote error) for I2C requests.
- R5: txn_status 1 (timeout) ends the request with result 1 and txn_status 3 (error) ends it with result 2, with no retry. txn_status 2 (busy) reissues the request with txn_start on the clock after the completion.
- R6: For native requests the native reply field is txn_reply[1:0]: 0 ACK, 1 NACK, 2 DEFER. ACK completes with result 0. DEFER waits DEFER_CYCLES cycles, and txn_start reappears DEFER_CYCLES+1 clocks after the completion. Any other native reply gives result 2.
- R7: A native read that gets a reply other than ACK or DEFER with txn_rx_count 0 gives result 3 (protocol error) instead of result 2.
- R8: For I2C requests the I2C reply field txn_reply[3:2] (0 ACK, 1 NACK, 2 DEFER) is used only when the native field is ACK. I2C ACK gives result 0. I2C DEFER waits like a native DEFER. I2C NACK or invalid, and native NACK or invalid, give result 4 whatever the I2C field holds.
- R9: For I2C requests without req_stop, bit 2 of the command nibble (txn_hdr[22]) is set. An address-only request has length byte 0x30.
- R10: On result 0, rd_count is txn_rx_count clipped to the receive size (len for a native read, 0 for a native write, 1 for I2C) and rd_data carries the received bytes. On any other result rd_count is 0.
- R11: done is a one-cycle pulse. req_ready is high only while no request is in progress. txn_start is a one-cycle pulse that never occurs while req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_kind | input | 3 | Request family code |
| req_stop | input | 1 | I2C transfer ends with a stop |
| req_addr | input | 16 | Target address |
| req_len | input | LEN_W | Byte count for native requests |
| req_wdata | input | 8*MAX_PAYLOAD | Write payload, byte 0 in the low bits |
| done | output | 1 | Result valid pulse |
| result | output | 3 | Result code |
| rd_count | output | LEN_W | Received bytes, clipped |
| rd_data | output | 8*MAX_PAYLOAD | Received bytes |
| txn_start | output | 1 | Issue a transaction |
| txn_hdr | output | 32 | Four-byte request header |
| txn_msg_len | output | MSG_W | Total message bytes |
| txn_wdata | output | 8*MAX_PAYLOAD | Payload for the engine |
| txn_done | input | 1 | Engine completion pulse |
| txn_status | input | 2 | Link status of the completion |
| txn_reply | input | 4 | Reply command nibble |
| txn_rx_count | input | LEN_W | Bytes the engine received |
| txn_rx_data | input | 8*MAX_PAYLOAD | Bytes the engine received |

## Verification
Native and I2C requests are each driven through scripted reply sequences. The single-attempt sequences ACK, NACK, timeout and error separate the terminating outcomes from one another. Mixed busy and defer sequences show that the two retry paths space their reissues differently: one clock after a busy, DEFER_CYCLES+1 after a defer. The I2C replies that pair a non-ACK native field with an I2C field that would have meant retry show the I2C field is ignored, and a zero-versus-nonzero byte count on a rejected native read separates the protocol error from the I/O error. Length 0, 16 and 17, over-long returned counts, and four consecutive busy or defer replies cover the boundaries.

// File: rtl/aux_req_pkg.sv
`timescale 1ns/1ps
package aux_req_pkg;

    typedef enum logic [2:0] {
        KIND_NAT_WR   = 3'd0,
        KIND_NAT_RD   = 3'd1,
        KIND_I2C_WR   = 3'd2,
        KIND_I2C_RD   = 3'd3,
        KIND_I2C_ADDR = 3'd4
    } req_kind_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_TIMEOUT = 3'd1,
        RES_IO      = 3'd2,
        RES_PROTO   = 3'd3,
        RES_REMOTE  = 3'd4,
        RES_BADREQ  = 3'd5
    } result_e;

    typedef enum logic [1:0] {
        LS_OK      = 2'd0,
        LS_TIMEOUT = 2'd1,
        LS_BUSY    = 2'd2,
        LS_ERROR   = 2'd3
    } link_status_e;

    typedef enum logic [1:0] {
        ACT_DONE,
        ACT_FAIL,
        ACT_RETRY,
        ACT_WAIT
    } action_e;

    // reply field codes, shared by the native and I2C fields
    localparam logic [1:0] RPL_ACK   = 2'd0;
    localparam logic [1:0] RPL_DEFER = 2'd2;

    // command nibbles
    localparam logic [3:0] CMD_NAT_WR = 4'h8;
    localparam logic [3:0] CMD_NAT_RD = 4'h9;
    localparam logic [3:0] CMD_I2C_WR = 4'h0;
    localparam logic [3:0] CMD_I2C_RD = 4'h1;
    localparam logic [3:0] CMD_MOT    = 4'h4;

    typedef struct packed {
        logic [7:0] len_byte;
        logic [7:0] cmd_byte;
        logic [7:0] addr_hi;
        logic [7:0] addr_lo;
    } aux_hdr_t;

    function automatic logic kind_is_native(logic [2:0] k);
        return (k == KIND_NAT_WR) || (k == KIND_NAT_RD);
    endfunction

    function automatic logic req_shape_ok(logic [2:0] k, int unsigned len,
                                          int unsigned max_payload);
        if (k > KIND_I2C_ADDR)
            return 1'b0;
        if (kind_is_native(k))
            return (len >= 1) && (len <= max_payload);
        return 1'b1;
    endfunction

endpackage

// File: rtl/aux_hdr_build.sv
`timescale 1ns/1ps
module aux_hdr_build
    import aux_req_pkg::*;
#(
    parameter int LEN_W = 5,
    parameter int MSG_W = 5
) (
    input  logic [2:0]       kind,
    input  logic             stop,
    input  logic [15:0]      addr,
    input  logic [LEN_W-1:0] len,
    output aux_hdr_t         hdr,
    output logic [MSG_W-1:0] msg_len,
    output logic [LEN_W-1:0] recv_size
);

    logic [7:0] len8;
    logic [3:0] mot;

    assign len8 = 8'(len);
    assign mot  = stop ? 4'h0 : CMD_MOT;

    always_comb begin
        hdr.addr_lo = addr[7:0];
        hdr.addr_hi = addr[15:8];
        hdr.cmd_byte = 8'h00;
        hdr.len_byte = 8'h00;
        msg_len = MSG_W'(4);
        recv_size = '0;
        case (kind)
            KIND_NAT_WR: begin
                hdr.cmd_byte = {CMD_NAT_WR, 4'h0};
                hdr.len_byte = {4'(len8 + 8'd4), 4'(len8 - 8'd1)};
                msg_len = MSG_W'(len8 + 8'd4);
            end
            KIND_NAT_RD: begin
                hdr.cmd_byte = {CMD_NAT_RD, 4'h0};
                hdr.len_byte = {4'h4, 4'(len8 - 8'd1)};
                recv_size = len;
            end
            KIND_I2C_WR: begin
                hdr.cmd_byte = {CMD_I2C_WR | mot, 4'h0};
                hdr.len_byte = 8'h50;
                msg_len = MSG_W'(5);
                recv_size = LEN_W'(1);
            end
            KIND_I2C_RD: begin
                hdr.cmd_byte = {CMD_I2C_RD | mot, 4'h0};
                hdr.len_byte = 8'h40;
                recv_size = LEN_W'(1);
            end
            default: begin
                hdr.cmd_byte = {CMD_I2C_WR | mot, 4'h0};
                hdr.len_byte = 8'h30;
                recv_size = LEN_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/aux_reply_classify.sv
`timescale 1ns/1ps
module aux_reply_classify
    import aux_req_pkg::*;
(
    input  logic [2:0] kind,
    input  logic [1:0] status,
    input  logic [3:0] reply,
    input  logic       rx_zero,
    output action_e    act,
    output result_e    code
);

    logic [1:0] nat_fld;
    logic [1:0] i2c_fld;

    assign nat_fld = reply[1:0];
    assign i2c_fld = reply[3:2];

    always_comb begin
        act  = ACT_FAIL;
        code = RES_IO;
        case (link_status_e'(status))
            LS_TIMEOUT: code = RES_TIMEOUT;
            LS_ERROR:   code = RES_IO;
            LS_BUSY:    act  = ACT_RETRY;
            default: begin
                if (kind_is_native(kind)) begin
                    if (nat_fld == RPL_ACK)
                        act = ACT_DONE;
                    else if (nat_fld == RPL_DEFER)
                        act = ACT_WAIT;
                    else if ((kind == KIND_NAT_RD) && rx_zero)
                        code = RES_PROTO;
                end else begin
                    code = RES_REMOTE;
                    if (nat_fld == RPL_ACK) begin
                        if (i2c_fld == RPL_ACK)
                            act = ACT_DONE;
                        else if (i2c_fld == RPL_DEFER)
                            act = ACT_WAIT;
                    end else if (nat_fld == RPL_DEFER) begin
                        act = ACT_WAIT;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/aux_defer_timer.sv
`timescale 1ns/1ps
module aux_defer_timer #(
    parameter int CYCLES = 80000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CW'(CYCLES - 1);
        else if (run && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/aux_req_ctrl.sv
`timescale 1ns/1ps
module aux_req_ctrl
    import aux_req_pkg::*;
#(
    parameter int MAX_PAYLOAD  = 16,
    parameter int MAX_TRIES    = 4,
    parameter int DEFER_CYCLES = 80000,
    localparam int LEN_W = $clog2(MAX_PAYLOAD + 1),
    localparam int MSG_W = $clog2(MAX_PAYLOAD + 5),
    localparam int DW    = MAX_PAYLOAD * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_kind,
    input  logic             req_stop,
    input  logic [15:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [DW-1:0]    req_wdata,
    output logic             done,
    output logic [2:0]       result,
    output logic [LEN_W-1:0] rd_count,
    output logic [DW-1:0]    rd_data,
    output logic             txn_start,
    output logic [31:0]      txn_hdr,
    output logic [MSG_W-1:0] txn_msg_len,
    output logic [DW-1:0]    txn_wdata,
    input  logic             txn_done,
    input  logic [1:0]       txn_status,
    input  logic [3:0]       txn_reply,
    input  logic [LEN_W-1:0] txn_rx_count,
    input  logic [DW-1:0]    txn_rx_data
);

    localparam int TRY_W = $clog2(MAX_TRIES + 1);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DEFER} state_e;

    state_e           state;
    logic [2:0]       kind_q;
    logic             stop_q;
    logic [15:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic [DW-1:0]    wdata_q;
    logic [TRY_W-1:0] tries_q;
    logic             done_q;
    result_e          result_q;
    logic [LEN_W-1:0] rd_count_q;
    logic [DW-1:0]    rd_data_q;

    aux_hdr_t         hdr;
    logic [LEN_W-1:0] recv_size;
    logic [LEN_W-1:0] clip_cnt;
    action_e          act;
    result_e          fail_code;
    result_e          spent_code;
    logic             last_try;
    logic             timer_load;
    logic             timer_expired;
    logic             req_ok;

    aux_hdr_build #(.LEN_W(LEN_W), .MSG_W(MSG_W)) u_hdr (
        .kind      (kind_q),
        .stop      (stop_q),
        .addr      (addr_q),
        .len       (len_q),
        .hdr       (hdr),
        .msg_len   (txn_msg_len),
        .recv_size (recv_size)
    );

    aux_reply_classify u_cls (
        .kind    (kind_q),
        .status  (txn_status),
        .reply   (txn_reply),
        .rx_zero (txn_rx_count == '0),
        .act     (act),
        .code    (fail_code)
    );

    aux_defer_timer #(.CYCLES(DEFER_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .run     (state == S_DEFER),
        .expired (timer_expired)
    );

    assign req_ok     = req_shape_ok(req_kind, 32'(req_len), MAX_PAYLOAD);
    assign last_try   = (tries_q == TRY_W'(MAX_TRIES));
    assign spent_code = kind_is_native(kind_q) ? RES_IO : RES_REMOTE;
    assign clip_cnt   = (txn_rx_count > recv_size) ? recv_size : txn_rx_count;
    assign timer_load = (state == S_WAIT) && txn_done && (act == ACT_WAIT) && !last_try;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            kind_q     <= KIND_NAT_WR;
            stop_q     <= 1'b0;
            addr_q     <= '0;
            len_q      <= '0;
            wdata_q    <= '0;
            tries_q    <= '0;
            done_q     <= 1'b0;
            result_q   <= RES_OK;
            rd_count_q <= '0;
            rd_data_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        kind_q  <= req_kind;
                        stop_q  <= req_stop;
                        addr_q  <= req_addr;
                        len_q   <= req_len;
                        wdata_q <= req_wdata;
                        tries_q <= '0;
                        if (req_ok) begin
                            state <= S_ISSUE;
                        end else begin
                            done_q     <= 1'b1;
                            result_q   <= RES_BADREQ;
                            rd_count_q <= '0;
                        end
                    end
                end
                S_ISSUE: begin
                    tries_q <= tries_q + 1'b1;
                    state   <= S_WAIT;
                end
                S_WAIT: begin
                    if (txn_done) begin
                        case (act)
                            ACT_DONE: begin
                                state      <= S_IDLE;
                                done_q     <= 1'b1;
                                result_q   <= RES_OK;
                                rd_count_q <= clip_cnt;
                                rd_data_q  <= txn_rx_data;
                            end
                            ACT_FAIL: begin
                                state      <= S_IDLE;
                                done_q     <= 1'b1;
                                result_q   <= fail_code;
                                rd_count_q <= '0;
                            end
                            default: begin
                                if (last_try) begin
                                    state      <= S_IDLE;
                                    done_q     <= 1'b1;
                                    result_q   <= spent_code;
                                    rd_count_q <= '0;
                                end else if (act == ACT_RETRY) begin
                                    state <= S_ISSUE;
                                end else begin
                                    state <= S_DEFER;
                                end
                            end
                        endcase
                    end
                end
                default: begin
                    if (timer_expired)
                        state <= S_ISSUE;
                end
            endcase
        end
    end

    assign req_ready = (state == S_IDLE);
    assign txn_start = (state == S_ISSUE);
    assign txn_hdr   = hdr;
    assign txn_wdata = wdata_q;
    assign done      = done_q;
    assign result    = result_q;
    assign rd_count  = rd_count_q;
    assign rd_data   = rd_data_q;

endmodule

// File: rtl/aux_req_ctrl_chk.sv
`timescale 1ns/1ps
module aux_req_ctrl_chk #(
    parameter int MAX_PAYLOAD = 16,
    parameter int MAX_TRIES   = 4,
    parameter int LEN_W       = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_kind,
    input logic             req_stop,
    input logic [15:0]      req_addr,
    input logic [LEN_W-1:0] req_len,
    input logic             done,
    input logic [2:0]       result,
    input logic [LEN_W-1:0] rd_count,
    input logic             txn_start,
    input logic [15:0]      hdr_addr,
    input logic             hdr_mot
);

    logic        accept;
    logic [15:0] addr_seen;
    logic [2:0]  kind_seen;
    logic        stop_seen;
    logic [7:0]  starts_seen;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_seen   <= '0;
            kind_seen   <= '0;
            stop_seen   <= 1'b1;
            starts_seen <= '0;
        end else if (accept) begin
            addr_seen   <= req_addr;
            kind_seen   <= req_kind;
            stop_seen   <= req_stop;
            starts_seen <= '0;
        end else if (txn_start) begin
            starts_seen <= starts_seen + 8'd1;
        end
    end

    assert_addr_bytes_R1: assert property (@(posedge clk) disable iff (rst)
        txn_start |-> (hdr_addr == addr_seen));

    assert_bad_len_rejected_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_kind <= 3'd1) && ((req_len == '0) || (req_len > LEN_W'(MAX_PAYLOAD))))
        |=> (done && (result == 3'd5) && !txn_start));

    assert_try_limit_R4: assert property (@(posedge clk) disable iff (rst)
        32'(starts_seen) <= MAX_TRIES);

    assert_mot_bit_R9: assert property (@(posedge clk) disable iff (rst)
        (txn_start && (kind_seen >= 3'd2) && (kind_seen <= 3'd4)) |-> (hdr_mot == !stop_seen));

    assert_count_clip_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(rd_count) <= MAX_PAYLOAD));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        txn_start |=> !txn_start);

    assert_start_not_idle_R11: assert property (@(posedge clk) disable iff (rst)
        txn_start |-> !req_ready);

endmodule

bind aux_req_ctrl aux_req_ctrl_chk #(
    .MAX_PAYLOAD (MAX_PAYLOAD),
    .MAX_TRIES   (MAX_TRIES),
    .LEN_W       (LEN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .req_stop  (req_stop),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .done      (done),
    .result    (result),
    .rd_count  (rd_count),
    .txn_start (txn_start),
    .hdr_addr  (txn_hdr[15:0]),
    .hdr_mot   (txn_hdr[22])
);

// File: tb/aux_req_ctrl_bench.sv
`timescale 1ns/1ps
module aux_req_ctrl_bench;

    localparam int MAXP = 16;
    localparam int DEF  = 12;
    localparam int LW   = 5;
    localparam int MW   = 5;
    localparam int DW   = MAXP * 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_kind = '0;
    logic          req_stop = 1'b0;
    logic [15:0]   req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          done;
    logic [2:0]    result;
    logic [LW-1:0] rd_count;
    logic [DW-1:0] rd_data;
    logic          txn_start;
    logic [31:0]   txn_hdr;
    logic [MW-1:0] txn_msg_len;
    logic [DW-1:0] txn_wdata;
    logic          txn_done = 1'b0;
    logic [1:0]    txn_status = '0;
    logic [3:0]    txn_reply = '0;
    logic [LW-1:0] txn_rx_count = '0;
    logic [DW-1:0] txn_rx_data = '0;

    aux_req_ctrl #(.MAX_PAYLOAD(MAXP), .MAX_TRIES(4), .DEFER_CYCLES(DEF)) u_aux_req_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_stop(req_stop), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .done(done), .result(result), .rd_count(rd_count),
        .rd_data(rd_data), .txn_start(txn_start), .txn_hdr(txn_hdr),
        .txn_msg_len(txn_msg_len), .txn_wdata(txn_wdata), .txn_done(txn_done),
        .txn_status(txn_status), .txn_reply(txn_reply), .txn_rx_count(txn_rx_count),
        .txn_rx_data(txn_rx_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // reply script
    logic [1:0]    rs [8];
    logic [3:0]    rr [8];
    int            rc [8];
    int            n_rep = 0;
    logic [DW-1:0] rxd = '0;

    // responder record
    int            rep_idx = 0;
    int            lat = 0;
    bit            pending = 0;
    bit            counting = 0;
    int            since_done = 0;
    int            starts = 0;
    logic [31:0]   hdr_seen [8];
    int            msg_seen [8];
    int            gap_seen [8];
    logic [DW-1:0] wd_seen = '0;

    // expectations
    int exp_att, exp_res, exp_cnt;
    int exp_gap [8];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic add_rep(input logic [1:0] st, input logic [3:0] rp, input int cnt);
        rs[n_rep] = st;
        rr[n_rep] = rp;
        rc[n_rep] = cnt;
        n_rep++;
    endtask

    // engine model: answers each txn_start after a fixed latency
    always @(negedge clk) begin
        if (txn_done) txn_done = 1'b0;
        if (counting) since_done++;
        if (!rst && txn_start) begin
            if (starts < 8) begin
                hdr_seen[starts] = txn_hdr;
                msg_seen[starts] = int'(txn_msg_len);
                gap_seen[starts] = since_done;
            end
            if (starts == 0) wd_seen = txn_wdata;
            starts++;
            pending = 1;
            lat = 0;
            counting = 0;
        end else if (pending) begin
            lat++;
            if (lat == 3) begin
                txn_status   = rs[rep_idx];
                txn_reply    = rr[rep_idx];
                txn_rx_count = LW'(rc[rep_idx]);
                txn_rx_data  = rxd;
                txn_done     = 1'b1;
                if (rep_idx < 7) rep_idx++;
                pending    = 0;
                counting   = 1;
                since_done = 0;
            end
        end
    end

    // behavioural expectation from the requirement text
    task automatic model(input int kind, input int len);
        bit native;
        int recv;
        int ok_i;
        native  = (kind < 2);
        recv    = (kind == 1) ? len : ((kind == 0) ? 0 : 1);
        exp_res = -1;
        exp_att = 0;
        exp_cnt = 0;
        ok_i    = 0;
        for (int i = 0; i < 8; i++) exp_gap[i] = 0;
        if (kind > 4 || (native && (len < 1 || len > MAXP))) begin
            exp_res = 5;
            return;
        end
        for (int i = 0; i < 4; i++) begin
            exp_att = i + 1;
            if (rs[i] == 2'd1) begin exp_res = 1; break; end
            if (rs[i] == 2'd3) begin exp_res = 2; break; end
            if (rs[i] == 2'd2) begin exp_gap[i+1] = 1; continue; end
            if (native) begin
                if (rr[i][1:0] == 2'd0) begin exp_res = 0; ok_i = i; break; end
                if (rr[i][1:0] == 2'd2) begin exp_gap[i+1] = DEF + 1; continue; end
                exp_res = (kind == 1 && rc[i] == 0) ? 3 : 2;
                break;
            end else begin
                if (rr[i][1:0] == 2'd0) begin
                    if (rr[i][3:2] == 2'd0) begin exp_res = 0; ok_i = i; break; end
                    if (rr[i][3:2] == 2'd2) begin exp_gap[i+1] = DEF + 1; continue; end
                    exp_res = 4;
                    break;
                end
                if (rr[i][1:0] == 2'd2) begin exp_gap[i+1] = DEF + 1; continue; end
                exp_res = 4;
                break;
            end
        end
        if (exp_res < 0) exp_res = native ? 2 : 4;
        if (exp_res == 0) exp_cnt = (rc[ok_i] > recv) ? recv : rc[ok_i];
    endtask

    task automatic run_req(input string tag, input int kind, input bit stop,
                           input logic [15:0] addr, input int len,
                           input logic [DW-1:0] wdata);
        logic [7:0] b2, b3;
        int msg;
        int cyc;
        model(kind, len);
        @(negedge clk);
        starts = 0; rep_idx = 0; pending = 0; counting = 0; since_done = 0;
        req_kind = 3'(kind); req_stop = stop; req_addr = addr;
        req_len = LW'(len); req_wdata = wdata; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        forever begin
            chk(req_ready === done, "R11", "ready vs done", req_ready, done);
            if (done) break;
            if (cyc > 2000) begin
                chk(0, tag, "no done", 0, 1);
                break;
            end
            @(negedge clk);
            cyc++;
        end
        chk(result == 3'(exp_res), tag, "result", result, exp_res);
        chk(int'(rd_count) == exp_cnt, "R10", "rd_count", rd_count, exp_cnt);
        for (int i = 0; i < exp_cnt; i++)
            chk(rd_data[8*i +: 8] == rxd[8*i +: 8], "R10", "rd byte", rd_data[8*i +: 8], rxd[8*i +: 8]);
        chk(starts == exp_att, "R4", "attempt count", starts, exp_att);
        // expected header
        case (kind)
            0: begin b2 = 8'h80; b3 = {4'(len + 4), 4'(len - 1)}; msg = len + 4; end
            1: begin b2 = 8'h90; b3 = {4'h4, 4'(len - 1)}; msg = 4; end
            2: begin b2 = stop ? 8'h00 : 8'h40; b3 = 8'h50; msg = 5; end
            3: begin b2 = stop ? 8'h10 : 8'h50; b3 = 8'h40; msg = 4; end
            default: begin b2 = stop ? 8'h00 : 8'h40; b3 = 8'h30; msg = 4; end
        endcase
        for (int i = 0; i < starts && i < 8; i++) begin
            chk(hdr_seen[i][15:0] == addr, "R1", "address bytes", hdr_seen[i][15:0], addr);
            chk(hdr_seen[i][23:16] == b2, (kind >= 2) ? "R9" : "R1", "command byte", hdr_seen[i][23:16], b2);
            chk(hdr_seen[i][31:24] == b3, (kind == 4) ? "R9" : "R2", "length byte", hdr_seen[i][31:24], b3);
            chk(msg_seen[i] == msg, "R2", "message length", msg_seen[i], msg);
            if (i > 0)
                chk(gap_seen[i] == exp_gap[i], (exp_gap[i] == 1) ? "R5" : "R6", "retry spacing", gap_seen[i], exp_gap[i]);
        end
        if (starts > 0 && kind == 0)
            for (int i = 0; i < len; i++)
                chk(wd_seen[8*i +: 8] == wdata[8*i +: 8], "R2", "payload byte", wd_seen[8*i +: 8], wdata[8*i +: 8]);
        if (starts > 0 && kind == 2)
            chk(wd_seen[7:0] == wdata[7:0], "R2", "i2c payload", wd_seen[7:0], wdata[7:0]);
        @(negedge clk);
        chk(!done, "R11", "done single pulse", done, 0);
        n_rep = 0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "reset ready", req_ready, 1);
        chk(done == 1'b0, "R11", "reset done", done, 0);
        chk(txn_start == 1'b0, "R11", "reset start", txn_start, 0);

        // R1 R2 R6: native write, immediate ACK
        add_rep(2'd0, 4'h0, 0);
        run_req("R6", 0, 1'b0, 16'hA51C, 3, {104'h0, 24'h33_22_11});

        // R6 R10: native read, DEFER then ACK
        rxd = 128'h0F0E0D0C_0B0A0908_07060504_DDCCBBAA;
        add_rep(2'd0, 4'h2, 0);
        add_rep(2'd0, 4'h0, 4);
        run_req("R6", 1, 1'b1, 16'h0200, 4, '0);

        // R10: returned count larger than requested
        add_rep(2'd0, 4'h0, 9);
        run_req("R10", 1, 1'b0, 16'h0010, 2, '0);

        // R5 R2: maximum write, busy twice then ACK
        add_rep(2'd2, 4'h0, 0);
        add_rep(2'd2, 4'h0, 0);
        add_rep(2'd0, 4'h0, 0);
        run_req("R5", 0, 1'b0, 16'h0103, 16, 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F);

        // R3: oversize write and zero-length read rejected
        add_rep(2'd0, 4'h0, 0);
        run_req("R3", 0, 1'b0, 16'h0001, 17, '1);
        add_rep(2'd0, 4'h0, 0);
        run_req("R3", 1, 1'b0, 16'h0002, 0, '0);
        add_rep(2'd0, 4'h0, 0);
        run_req("R3", 6, 1'b0, 16'h0003, 1, '0);

        // R4: four deferrals, four busies, four I2C native deferrals
        for (int i = 0; i < 4; i++) add_rep(2'd0, 4'h2, 0);
        run_req("R4", 1, 1'b0, 16'h0300, 1, '0);
        for (int i = 0; i < 4; i++) add_rep(2'd2, 4'h0, 0);
        run_req("R4", 0, 1'b0, 16'h0301, 1, 128'h5A);
        for (int i = 0; i < 4; i++) add_rep(2'd0, 4'h2, 0);
        run_req("R4", 4, 1'b1, 16'h0050, 0, '0);

        // R5: timeout and error abort at once
        add_rep(2'd1, 4'h0, 0);
        run_req("R5", 1, 1'b0, 16'h0400, 1, '0);
        add_rep(2'd3, 4'h0, 0);
        run_req("R5", 3, 1'b1, 16'h0050, 0, '0);

        // R7: native read NACK with zero bytes vs with bytes
        add_rep(2'd0, 4'h1, 0);
        run_req("R7", 1, 1'b0, 16'h0500, 3, '0);
        add_rep(2'd0, 4'h1, 2);
        run_req("R6", 1, 1'b0, 16'h0501, 3, '0);
        add_rep(2'd0, 4'h1, 0);
        run_req("R6", 0, 1'b0, 16'h0502, 2, 128'h7788);

        // R8 R9: I2C read without stop, I2C DEFER then ACK with one byte
        rxd = 128'h000000000000000000000000_0000C3A7;
        add_rep(2'd0, 4'h8, 0);
        add_rep(2'd0, 4'h0, 3);
        run_req("R8", 3, 1'b0, 16'h0050, 0, '0);

        // R8: I2C write with stop, I2C NACK
        add_rep(2'd0, 4'h4, 0);
        run_req("R8", 2, 1'b1, 16'h0050, 0, 128'h9E);

        // R8: native NACK with an I2C DEFER field is not retried
        add_rep(2'd0, 4'h9, 0);
        add_rep(2'd0, 4'h0, 1);
        run_req("R8", 3, 1'b1, 16'h0051, 0, '0);

        // R8 R9: address-only, native ACK then I2C ACK
        add_rep(2'd0, 4'h0, 0);
        run_req("R9", 4, 1'b0, 16'h0052, 0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule